// File: doc/BRIEF.md
# Free-Running Timer with Modulo Compare

This block holds a free-running time count that advances by one on each tick of a programmable prescaler and wraps to zero past the top of its range. Any number of client read ports can capture the current count. The count is treated as a signed integer of the word width.

A single wait port lets a requester hand over a target time through a valid/ready handshake. The block then holds the request. It raises a one-cycle release pulse once the count has moved past the target. "Past" is judged by modulo ordering: the half range ahead of the count is the future and the half range behind it is the past. Because of this, wrap-around needs no special case. Only one wait can be outstanding at a time.

The block is meant to sit next to a scheduler that keeps the waiting tasks. The scheduler posts the earliest target here and wakes the task on release.

Top module: `modulo_timer`

## Requirements
- R1: While `rst_n` is low the block clears the count and every read port to zero, holds `wait_ready` high and `wait_release` low, and drops any armed wait.
- R2: With divide value `div_i` = N, a tick occurs once every N+1 clock cycles, and the count steps by exactly one per tick. With N = 0 it steps on every cycle.
- R3: The count wraps from all ones to zero and keeps counting.
- R4: Read port i uses `rd_en[i]` and the field `rd_data[i*WIDTH +: WIDTH]`. When `rd_en[i]` is high at a clock edge, the field shows the count from before that edge one cycle later. When `rd_en[i]` is low, the field holds its value. Each port works on its own.
- R5: Value a is after value b exactly when (a − b), truncated to WIDTH bits, has its top bit clear and is non-zero.
- R6: `wait_release` is high for exactly one cycle. It rises in the cycle after the first tick at which a wait is armed and the count before that tick is after the target.
- R7: A target up to and including 2^(WIDTH−1) ahead of the count keeps the wait armed until the count passes it. A target equal to the count, or any nearer value behind it, releases on the first evaluated tick.
- R8: `wait_ready` is high exactly when no wait is armed. A request is taken when `wait_valid` and `wait_ready` are both high at a clock edge. A request offered while `wait_ready` is low is ignored.
- R9: A reset while a wait is armed cancels it, and no release follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_i | input | PRESC_W | Prescaler divide value; tick every div_i+1 cycles |
| rd_en | input | NUM_RD | Per-port capture enable |
| rd_data | output | NUM_RD*WIDTH | Captured count, one WIDTH field per port |
| wait_valid | input | 1 | Wait request valid |
| wait_ready | output | 1 | No wait armed; a request can be taken |
| wait_target | input | WIDTH | Target time of the request |
| wait_release | output | 1 | One-cycle pulse when the target has passed |

## Verification
The bench drives targets around the half-range boundary. A target exactly half a range ahead must wait, while one step further must release at once. An unsigned or plain magnitude compare would either release too early or hang until the count wraps. Targets equal to or just behind the count check that the compare is strict: a design using "not before" in place of "after" would release one count too soon. Targets placed across the wrap point, a second request offered while one is armed, a slow prescaler setting and a reset during an armed wait show whether the design drops requests it should keep, accepts requests it should ignore, releases between ticks, or leaves a stale wait armed.

// File: rtl/modulo_timer_pkg.sv
// Package: shared types for the modulo timer.
// Assumes: nothing beyond IEEE 1800-2017.
package modulo_timer_pkg;

    // State of the single wait slot.
    typedef enum logic {
        SLOT_FREE  = 1'b0,
        SLOT_ARMED = 1'b1
    } slot_state_e;

endpackage

// File: rtl/tick_divider.sv
// Module: tick_divider
// Produces a one-cycle tick every DIV+1 clock cycles, where DIV is sampled
// each cycle. Assumes the divide value may change at any time; a count
// already past a lowered divide value fires at once.
module tick_divider #(
    parameter int PRESC_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] div_i,
    output logic               tick_o
);

    logic [PRESC_W-1:0] phase_q;

    // Tick when the phase has reached the divide value.
    always_comb begin
        tick_o = (phase_q >= div_i);
    end

    // Advance the phase, restarting after each tick.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (tick_o) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PRESC_W'(1);
        end
    end

endmodule

// File: rtl/time_counter.sv
// Module: time_counter
// The free-running count itself. Steps by one on each tick, wraps naturally.
// Assumes tick_i is a single-cycle strobe from the divider.
module time_counter #(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [WIDTH-1:0] now_o
);

    logic [WIDTH-1:0] count_q;

    // Step the count on each tick; hold otherwise.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick_i) begin
            count_q <= count_q + WIDTH'(1);
        end
    end

    assign now_o = count_q;

endmodule

// File: rtl/time_snapshot.sv
// Module: time_snapshot
// One client read port: captures the count when enabled, holds it otherwise.
// Assumes the consumer samples the field one cycle after raising enable.
module time_snapshot #(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [WIDTH-1:0] now_i,
    output logic [WIDTH-1:0] data_o
);

    logic [WIDTH-1:0] hold_q;

    // Capture the present count on enable.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (en_i) begin
            hold_q <= now_i;
        end
    end

    assign data_o = hold_q;

endmodule

// File: rtl/wait_unit.sv
// Module: wait_unit
// Holds one armed target and pulses release on the first tick at which the
// count is after it under modulo (signed difference) ordering.
// Assumes one outstanding request; later requests wait for ready.
module wait_unit #(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [WIDTH-1:0] now_i,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [WIDTH-1:0] req_target_i,
    output logic [WIDTH-1:0] target_o,
    output logic             release_o
);
    import modulo_timer_pkg::*;

    localparam int SIGN_BIT = WIDTH - 1;

    slot_state_e      slot_q;
    logic [WIDTH-1:0] target_q;
    logic [WIDTH-1:0] delta;
    logic             passed;
    logic             release_q;

    // Modulo order: positive non-zero signed difference means "after".
    always_comb begin
        delta  = now_i - target_q;
        passed = !delta[SIGN_BIT] && (delta != '0);
    end

    // Accept a request when free; release and free the slot once passed.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            slot_q    <= SLOT_FREE;
            target_q  <= '0;
            release_q <= 1'b0;
        end else begin
            release_q <= 1'b0;
            case (slot_q)
                SLOT_FREE: begin
                    if (req_valid_i) begin
                        target_q <= req_target_i;
                        slot_q   <= SLOT_ARMED;
                    end
                end
                SLOT_ARMED: begin
                    if (tick_i && passed) begin
                        release_q <= 1'b1;
                        slot_q    <= SLOT_FREE;
                    end
                end
                default: slot_q <= SLOT_FREE;
            endcase
        end
    end

    assign req_ready_o = (slot_q == SLOT_FREE);
    assign target_o    = target_q;
    assign release_o   = release_q;

endmodule

// File: rtl/modulo_timer.sv
// Module: modulo_timer (top)
// Free-running timer with a prescaler, NUM_RD capture ports and one
// modulo-compare wait port. Assumes a single clock and synchronous reset.
module modulo_timer #(
    parameter int WIDTH   = 32,
    parameter int PRESC_W = 8,
    parameter int NUM_RD  = 2
) (
    input  logic                    clk_i,
    input  logic                    rst_n,
    input  logic [PRESC_W-1:0]      div_i,
    input  logic [NUM_RD-1:0]       rd_en,
    output logic [NUM_RD*WIDTH-1:0] rd_data,
    input  logic                    wait_valid,
    output logic                    wait_ready,
    input  logic [WIDTH-1:0]        wait_target,
    output logic                    wait_release
);

    logic             tick_w;
    logic [WIDTH-1:0] now_w;
    logic [WIDTH-1:0] target_w;

    tick_divider #(.PRESC_W(PRESC_W)) u_div (
        .clk_i  (clk_i),
        .rst_n  (rst_n),
        .div_i  (div_i),
        .tick_o (tick_w)
    );

    time_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk_i  (clk_i),
        .rst_n  (rst_n),
        .tick_i (tick_w),
        .now_o  (now_w)
    );

    // One capture register per client port.
    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        time_snapshot #(.WIDTH(WIDTH)) u_snap (
            .clk_i  (clk_i),
            .rst_n  (rst_n),
            .en_i   (rd_en[p]),
            .now_i  (now_w),
            .data_o (rd_data[p*WIDTH +: WIDTH])
        );
    end

    wait_unit #(.WIDTH(WIDTH)) u_wait (
        .clk_i        (clk_i),
        .rst_n        (rst_n),
        .tick_i       (tick_w),
        .now_i        (now_w),
        .req_valid_i  (wait_valid),
        .req_ready_o  (wait_ready),
        .req_target_i (wait_target),
        .target_o     (target_w),
        .release_o    (wait_release)
    );

endmodule

// File: rtl/modulo_timer_chk.sv
// Module: modulo_timer_chk
// Assertion checker bound into modulo_timer. Observes the tick, the count,
// the armed target and the wait handshake.
module modulo_timer_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk_i,
    input logic             rst_n,
    input logic             tick,
    input logic [WIDTH-1:0] now,
    input logic [WIDTH-1:0] target,
    input logic             wait_valid,
    input logic             wait_ready,
    input logic             wait_release
);

    logic [WIDTH-1:0] gap_q;

    // Difference from the previous cycle, for the release check.
    always_ff @(posedge clk_i) begin
        gap_q <= now - target;
    end

    // R2
    tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        !tick |=> now == $past(now));

    // R2
    tick_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        tick |=> now == $past(now) + WIDTH'(1));

    // R6
    release_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        wait_release |=> !wait_release);

    // R6
    release_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        wait_release |-> $past(tick));

    // R5
    release_after_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        wait_release |-> (!gap_q[WIDTH-1] && gap_q != '0));

    // R8
    accept_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        (wait_valid && wait_ready) |=> !wait_ready);

    // R6
    release_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        wait_release |-> wait_ready);

    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
        !rst_n |=> (now == '0 && wait_ready && !wait_release));

endmodule

bind modulo_timer modulo_timer_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_i        (clk_i),
    .rst_n        (rst_n),
    .tick         (tick_w),
    .now          (now_w),
    .target       (target_w),
    .wait_valid   (wait_valid),
    .wait_ready   (wait_ready),
    .wait_release (wait_release)
);

// File: tb/modulo_timer_test.sv
module modulo_timer_test;
    localparam int W  = 8;
    localparam int PW = 4;
    localparam int NR = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] div = '0;
    logic [NR-1:0] rd_en = '0;
    logic [NR*W-1:0] rd_data;
    logic          wait_valid = 1'b0;
    logic          wait_ready;
    logic [W-1:0]  wait_target = '0;
    logic          wait_release;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    modulo_timer #(.WIDTH(W), .PRESC_W(PW), .NUM_RD(NR)) uut (
        .clk_i(clk), .rst_n(rst_n), .div_i(div), .rd_en(rd_en), .rd_data(rd_data),
        .wait_valid(wait_valid), .wait_ready(wait_ready),
        .wait_target(wait_target), .wait_release(wait_release)
    );

    always #10 clk = ~clk;

    function automatic logic [W-1:0] rd0();
        return rd_data[0 +: W];
    endfunction

    function automatic logic [W-1:0] rd1();
        return rd_data[W +: W];
    endfunction

    function automatic bit is_after(logic [W-1:0] a, logic [W-1:0] b);
        logic [W-1:0] d;
        d = a - b;
        return !d[W-1] && (d != '0);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // R1: reset values, sampled while reset is held.
    task automatic t_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(rd0() == 0, "R1", "port0 in reset", rd0(), 0);
        check(rd1() == 0, "R1", "port1 in reset", rd1(), 0);
        check(wait_ready == 1'b1, "R1", "ready in reset", wait_ready, 1);
        check(wait_release == 1'b0, "R1", "release in reset", wait_release, 0);
        rst_n = 1'b1;
    endtask

    // R2: with div 0 the count steps every cycle.
    task automatic t_count_fast();
        logic [W-1:0] prev;
        bit ok = 1'b1;
        int bad = 0;
        @(negedge clk);
        prev = rd0();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (rd0() != prev + W'(1)) begin ok = 1'b0; bad = rd0(); end
            prev = rd0();
        end
        check(ok, "R2", "step per cycle", bad, prev);
    endtask

    // R3: the count rolls from all ones to zero.
    task automatic t_wrap();
        int n = 0;
        while (rd0() != 8'hFF && n < 600) begin @(negedge clk); n++; end
        @(negedge clk);
        check(rd0() == 0, "R3", "wrap to zero", rd0(), 0);
    endtask

    // R4: independent capture and hold.
    task automatic t_read_ports();
        logic [W-1:0] held;
        @(negedge clk) rd_en[1] = 1'b1;
        @(negedge clk) rd_en[1] = 1'b0;
        check(rd1() == rd0(), "R4", "port1 capture", rd1(), rd0());
        held = rd1();
        for (int i = 0; i < 5; i++) @(negedge clk);
        check(rd1() == held, "R4", "port1 hold", rd1(), held);
        check(rd0() == held + W'(5), "R4", "port0 keeps moving", rd0(), held + 5);
    endtask

    // R2: a divide value of 3 steps the count every fourth cycle.
    task automatic t_prescale();
        logic [W-1:0] v;
        int n = 0;
        @(negedge clk) div = 4'd3;
        @(negedge clk);
        v = rd0();
        while (rd0() == v && n < 20) begin @(negedge clk); n++; end
        v = rd0();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(rd0() == v, "R2", "hold between ticks", rd0(), v);
        end
        @(negedge clk);
        check(rd0() == v + W'(1), "R2", "step on fourth cycle", rd0(), v + 1);
    endtask

    // R6: with a slow tick the release lands the cycle after the tick that sees target+1.
    task automatic t_wait_slow();
        logic [W-1:0] tgt;
        int n = 0;
        @(negedge clk);
        tgt = rd0() + W'(6);
        wait_target = tgt;
        wait_valid = 1'b1;
        @(negedge clk) wait_valid = 1'b0;
        while (!wait_release && n < 200) begin @(negedge clk); n++; end
        check(wait_release == 1'b1, "R6", "slow release seen", wait_release, 1);
        check(rd0() == tgt + W'(1), "R6", "slow release count", rd0(), tgt + 1);
        @(negedge clk);
        div = '0;
    endtask

    // R5 R6 R7: issue a wait offset from the count and compare to a model (div 0).
    task automatic t_wait(input int offset, input string req);
        logic [W-1:0] base, tgt, v;
        int n = 0;
        @(negedge clk);
        base = rd0();
        tgt = base + W'(offset);
        check(wait_ready == 1'b1, "R8", "ready before request", wait_ready, 1);
        wait_target = tgt;
        wait_valid = 1'b1;
        @(negedge clk) wait_valid = 1'b0;
        v = base + W'(2);
        while (!is_after(v, tgt)) v = v + W'(1);
        while (!wait_release && n < 400) begin @(negedge clk); n++; end
        check(wait_release == 1'b1, req, "release seen", wait_release, 1);
        check(rd0() == v, req, "count at release", rd0(), v);
        check(wait_ready == 1'b1, "R8", "ready at release", wait_ready, 1);
        @(negedge clk);
        check(wait_release == 1'b0, "R6", "single pulse", wait_release, 0);
    endtask

    // R8: a request offered while armed is ignored.
    task automatic t_wait_ignore();
        logic [W-1:0] base, tgt;
        int n = 0;
        @(negedge clk);
        base = rd0();
        tgt = base + W'(20);
        wait_target = tgt;
        wait_valid = 1'b1;
        @(negedge clk);
        check(wait_ready == 1'b0, "R8", "busy while armed", wait_ready, 0);
        wait_target = base + W'(3);
        @(negedge clk) wait_valid = 1'b0;
        while (!wait_release && n < 100) begin @(negedge clk); n++; end
        check(rd0() == tgt + W'(1), "R8", "second request ignored", rd0(), tgt + 1);
    endtask

    // R9: reset drops an armed wait.
    task automatic t_cancel();
        bit seen = 1'b0;
        @(negedge clk);
        wait_target = rd0() + W'(40);
        wait_valid = 1'b1;
        @(negedge clk) wait_valid = 1'b0;
        @(negedge clk);
        t_reset();
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (wait_release) seen = 1'b1;
        end
        check(!seen, "R9", "no release after reset", seen, 0);
        check(wait_ready == 1'b1, "R9", "ready after reset", wait_ready, 1);
    endtask

    initial begin
        rd_en[0] = 1'b1;
        t_reset();
        t_count_fast();
        t_read_ports();
        t_wrap();
        t_wait(5, "R6");
        t_wait(0, "R7");
        t_wait(-1, "R7");
        t_wait(-100, "R7");
        t_wait(127, "R5");
        t_wait(128, "R7");
        t_wait(129, "R7");
        // Target placed across the wrap point.
        while (rd0() != 8'd245) @(negedge clk);
        t_wait(20, "R3");
        t_wait_ignore();
        t_prescale();
        t_wait_slow();
        t_cancel();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule